// File: doc/BRIEF.md
# Shared Interrupt Line Router

This block sits between three banks of general-purpose pins and an interrupt controller. Bank 0 has 14 per-pin interrupt requests, bank 1 has 24 and bank 2 has 32. The controller has 41 inputs for them. The lowest 32 controller lines are shared. A 32-bit select register picks the source of each shared line separately. With its select bit clear, a line carries its default bank-0 or bank-1 request. With its select bit set, it carries the bank-2 request of the same index. Six further lines always carry the top six bank-1 requests.

A request that has no direct line under the current select value is not lost. It is folded into a per-bank OR line, and that OR line is only active while its enable bit is set. There are three OR lines, one per bank.

Software programs the select register and the three enables through a small write-only register port. All 41 outputs are registered, so the controller never sees combinational glitches from the multiplexers or the OR trees.

Top module: `irq_line_router`

## Requirements
- R1: During and after reset, before any write, the select register and the three OR-line enables are zero, and every output line is 0 on the cycle after reset. With select zero, no bank-2 request appears on any direct line (lines 0..31).
- R2: When select bit i is 0, line i carries bank-0 request i for i in 0..13, and bank-1 request i-14 for i in 14..31.
- R3: When select bit i is 1, line i carries bank-2 request i, for i in 0..31.
- R4: Lines 32..37 carry bank-1 requests 18..23, whatever the select value is.
- R5: Line 38 is 1 exactly when enable bit 0 is set and some bank-0 request i is high whose select bit i is 1.
- R6: Line 39 is 1 exactly when enable bit 1 is set and some bank-1 request j (j < 18) is high whose select bit 14+j is 1. Bank-1 requests 18..23 never affect line 39.
- R7: Line 40 is 1 exactly when enable bit 2 is set and some bank-2 request k is high whose select bit k is 0.
- R8: An OR line whose enable bit is 0 outputs 0, whatever its bank's requests are.
- R9: The register port behaves as follows:
  - A write with address 0 loads all 32 data bits into the select register.
  - A write with address 1 loads data bits 2..0 into the enables: bit 0 for line 38, bit 1 for line 39, bit 2 for line 40. Data bits 31..3 are ignored.
  - Without a write, both registers hold their values.
- R10: The outputs reflect the requests and configuration sampled at the previous rising clock edge. A write therefore changes the outputs on the second rising edge after it is presented, not the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank0_irq_i | input | 14 | Bank-0 per-pin interrupt requests |
| bank1_irq_i | input | 24 | Bank-1 per-pin interrupt requests |
| bank2_irq_i | input | 32 | Bank-2 per-pin interrupt requests |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 1 | Register select: 0 for the select register, 1 for the OR-line enables |
| cfg_wdata_i | input | 32 | Register write data |
| line_irq_o | output | 41 | Registered interrupt lines to the controller |

## Verification
Directed patterns cover four cases:
- All requests high with select zero and enables off. This separates the default routing from any bank-2 leak, and shows that disabled OR lines stay quiet.
- Select all ones with only bank 0 active. This shows the direct lines switching to bank 2 while bank 0 falls back to line 38.
- Only the top bank-1 requests active, with every select bit set. This shows that these requests never reach line 39.
- An enable write whose upper data bits are set, which shows those bits are ignored.

Random request vectors then run under random select and enable values. This mixes both routes for each line in the same vector, so a swapped index or an inverted select polarity on any single line shows up.

Each configuration write is also checked on the first cycle after the write edge, where the old mapping must still be visible. This separates the intended two-edge latency from a one-edge path.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int unsigned DEF_B0_N  = 14;
    localparam int unsigned DEF_B1_N  = 24;
    localparam int unsigned DEF_SEL_N = 32;
    localparam int unsigned OR_N      = 3;
    localparam int unsigned CFG_DW    = 32;

    typedef enum logic {
        REG_SELECT  = 1'b0,
        REG_FOLD_EN = 1'b1
    } reg_addr_e;

    typedef enum logic [1:0] {
        FOLD_B0 = 2'd0,
        FOLD_B1 = 2'd1,
        FOLD_B2 = 2'd2
    } fold_idx_e;

    typedef struct packed {
        logic              we;
        reg_addr_e         addr;
        logic [CFG_DW-1:0] data;
    } cfg_wr_t;

    function automatic logic [OR_N-1:0] fold_en_field(input logic [CFG_DW-1:0] d);
        return d[OR_N-1:0];
    endfunction

    function automatic logic wr_hits(input cfg_wr_t w, input reg_addr_e a);
        return w.we && (w.addr == a);
    endfunction

endpackage

// File: rtl/irq_route_cfg.sv
module irq_route_cfg
    import irq_route_pkg::*;
#(
    parameter int unsigned SEL_N = DEF_SEL_N
) (
    input  logic                clk,
    input  logic                rst,
    input  cfg_wr_t             wr,
    output logic [SEL_N-1:0]    sel_o,
    output logic [OR_N-1:0]     fold_en_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_o <= '0;
        end else if (wr_hits(wr, REG_SELECT)) begin
            sel_o <= wr.data[SEL_N-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fold_en_o <= '0;
        end else if (wr_hits(wr, REG_FOLD_EN)) begin
            fold_en_o <= fold_en_field(wr.data);
        end
    end

endmodule

// File: rtl/irq_route_xbar.sv
module irq_route_xbar
    import irq_route_pkg::*;
#(
    parameter int unsigned B0_N  = DEF_B0_N,
    parameter int unsigned B1_N  = DEF_B1_N,
    parameter int unsigned SEL_N = DEF_SEL_N,
    localparam int unsigned DIR1_N = SEL_N - B0_N,
    localparam int unsigned EXT_N  = B1_N - DIR1_N
) (
    input  logic [B0_N-1:0]        b0,
    input  logic [B1_N-1:0]        b1,
    input  logic [SEL_N-1:0]       b2,
    input  logic [SEL_N-1:0]       sel,
    output logic [SEL_N+EXT_N-1:0] direct
);

    for (genvar i = 0; i < SEL_N; i++) begin : g_shared
        logic home_src;
        if (i < B0_N) begin : g_from_b0
            assign home_src = b0[i];
        end else begin : g_from_b1
            assign home_src = b1[i-B0_N];
        end
        assign direct[i] = sel[i] ? b2[i] : home_src;
    end

    for (genvar j = 0; j < EXT_N; j++) begin : g_fixed
        assign direct[SEL_N+j] = b1[DIR1_N+j];
    end

endmodule

// File: rtl/irq_route_fold.sv
module irq_route_fold
    import irq_route_pkg::*;
#(
    parameter int unsigned B0_N  = DEF_B0_N,
    parameter int unsigned B1_N  = DEF_B1_N,
    parameter int unsigned SEL_N = DEF_SEL_N,
    localparam int unsigned DIR1_N = SEL_N - B0_N
) (
    input  logic [B0_N-1:0]  b0,
    input  logic [B1_N-1:0]  b1,
    input  logic [SEL_N-1:0] b2,
    input  logic [SEL_N-1:0] sel,
    input  logic [OR_N-1:0]  en,
    output logic [OR_N-1:0]  fold
);

    logic [B0_N-1:0]   lost0;
    logic [DIR1_N-1:0] lost1;
    logic [SEL_N-1:0]  lost2;

    // A bank-0/1 source is displaced when its line is given to bank 2;
    // a bank-2 source is displaced while its line stays at home.
    assign lost0 = b0 & sel[B0_N-1:0];
    assign lost1 = b1[DIR1_N-1:0] & sel[SEL_N-1:B0_N];
    assign lost2 = b2 & ~sel;

    always_comb begin
        fold          = '0;
        fold[FOLD_B0] = en[FOLD_B0] && (|lost0);
        fold[FOLD_B1] = en[FOLD_B1] && (|lost1);
        fold[FOLD_B2] = en[FOLD_B2] && (|lost2);
    end

endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
    import irq_route_pkg::*;
#(
    parameter int unsigned B0_N  = DEF_B0_N,
    parameter int unsigned B1_N  = DEF_B1_N,
    parameter int unsigned SEL_N = DEF_SEL_N,
    localparam int unsigned DIR1_N = SEL_N - B0_N,
    localparam int unsigned EXT_N  = B1_N - DIR1_N,
    localparam int unsigned LINES  = SEL_N + EXT_N + OR_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [B0_N-1:0]   bank0_irq_i,
    input  logic [B1_N-1:0]   bank1_irq_i,
    input  logic [SEL_N-1:0]  bank2_irq_i,
    input  logic              cfg_we_i,
    input  logic              cfg_addr_i,
    input  logic [CFG_DW-1:0] cfg_wdata_i,
    output logic [LINES-1:0]  line_irq_o
);

    cfg_wr_t                 wr;
    logic [SEL_N-1:0]        sel_q;
    logic [OR_N-1:0]         fold_en_q;
    logic [SEL_N+EXT_N-1:0]  direct;
    logic [OR_N-1:0]         fold;

    assign wr.we   = cfg_we_i;
    assign wr.addr = reg_addr_e'(cfg_addr_i);
    assign wr.data = cfg_wdata_i;

    irq_route_cfg #(.SEL_N(SEL_N)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .sel_o     (sel_q),
        .fold_en_o (fold_en_q)
    );

    irq_route_xbar #(.B0_N(B0_N), .B1_N(B1_N), .SEL_N(SEL_N)) u_xbar (
        .b0     (bank0_irq_i),
        .b1     (bank1_irq_i),
        .b2     (bank2_irq_i),
        .sel    (sel_q),
        .direct (direct)
    );

    irq_route_fold #(.B0_N(B0_N), .B1_N(B1_N), .SEL_N(SEL_N)) u_fold (
        .b0   (bank0_irq_i),
        .b1   (bank1_irq_i),
        .b2   (bank2_irq_i),
        .sel  (sel_q),
        .en   (fold_en_q),
        .fold (fold)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            line_irq_o <= '0;
        end else begin
            line_irq_o <= {fold, direct};
        end
    end

endmodule

// File: rtl/irq_line_router_chk.sv
module irq_line_router_chk
    import irq_route_pkg::*;
#(
    parameter int unsigned B0_N  = DEF_B0_N,
    parameter int unsigned B1_N  = DEF_B1_N,
    parameter int unsigned SEL_N = DEF_SEL_N,
    localparam int unsigned DIR1_N = SEL_N - B0_N,
    localparam int unsigned EXT_N  = B1_N - DIR1_N,
    localparam int unsigned LINES  = SEL_N + EXT_N + OR_N,
    localparam int unsigned FBASE  = SEL_N + EXT_N
) (
    input logic              clk,
    input logic              rst,
    input logic [B0_N-1:0]   b0,
    input logic [B1_N-1:0]   b1,
    input logic [SEL_N-1:0]  b2,
    input logic              we,
    input logic              addr,
    input logic [CFG_DW-1:0] wdata,
    input logic [SEL_N-1:0]  sel,
    input logic [OR_N-1:0]   en,
    input logic [LINES-1:0]  line
);

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (line == '0 && sel == '0 && en == '0));

    for (genvar i = 0; i < SEL_N; i++) begin : g_lane
        if (i < B0_N) begin : g_b0
            assert_home_b0_R2: assert property (@(posedge clk) disable iff (rst)
                armed && !$past(sel[i]) |-> line[i] == $past(b0[i]));
        end else begin : g_b1
            assert_home_b1_R2: assert property (@(posedge clk) disable iff (rst)
                armed && !$past(sel[i]) |-> line[i] == $past(b1[i-B0_N]));
        end
        assert_steal_b2_R3: assert property (@(posedge clk) disable iff (rst)
            armed && $past(sel[i]) |-> line[i] == $past(b2[i]));
    end

    assert_fixed_lines_R4: assert property (@(posedge clk) disable iff (rst)
        armed |-> line[FBASE-1:SEL_N] == $past(b1[B1_N-1:DIR1_N]));

    assert_fold_b0_R5: assert property (@(posedge clk) disable iff (rst)
        armed && $past(en[0]) |-> line[FBASE] == |($past(b0) & $past(sel[B0_N-1:0])));

    assert_fold_b1_R6: assert property (@(posedge clk) disable iff (rst)
        armed && $past(en[1]) |-> line[FBASE+1] == |($past(b1[DIR1_N-1:0]) & $past(sel[SEL_N-1:B0_N])));

    assert_fold_b2_R7: assert property (@(posedge clk) disable iff (rst)
        armed && $past(en[2]) |-> line[FBASE+2] == |($past(b2) & ~$past(sel)));

    for (genvar k = 0; k < OR_N; k++) begin : g_gate
        assert_fold_gated_R8: assert property (@(posedge clk) disable iff (rst)
            armed && !$past(en[k]) |-> !line[FBASE+k]);
    end

    assert_sel_load_R9: assert property (@(posedge clk) disable iff (rst)
        armed && $past(we) && !$past(addr) |-> sel == $past(wdata[SEL_N-1:0]));

    assert_en_load_R9: assert property (@(posedge clk) disable iff (rst)
        armed && $past(we) && $past(addr) |-> en == $past(wdata[OR_N-1:0]));

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        armed && !$past(we) |-> $stable(sel) && $stable(en));

endmodule

bind irq_line_router irq_line_router_chk #(
    .B0_N(B0_N), .B1_N(B1_N), .SEL_N(SEL_N)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .b0    (bank0_irq_i),
    .b1    (bank1_irq_i),
    .b2    (bank2_irq_i),
    .we    (cfg_we_i),
    .addr  (cfg_addr_i),
    .wdata (cfg_wdata_i),
    .sel   (sel_q),
    .en    (fold_en_q),
    .line  (line_irq_o)
);

// File: tb/irq_line_router_bench.sv
module irq_line_router_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] b0 = '0;
    logic [23:0] b1 = '0;
    logic [31:0] b2 = '0;
    logic        we = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wdata = '0;
    logic [40:0] line;

    logic [31:0] m_sel = '0;
    logic [2:0]  m_en  = '0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_line_router u_irq_line_router (
        .clk         (clk),
        .rst         (rst),
        .bank0_irq_i (b0),
        .bank1_irq_i (b1),
        .bank2_irq_i (b2),
        .cfg_we_i    (we),
        .cfg_addr_i  (addr),
        .cfg_wdata_i (wdata),
        .line_irq_o  (line)
    );

    function automatic logic [40:0] model(input logic [13:0] x0, input logic [23:0] x1,
                                          input logic [31:0] x2, input logic [31:0] s,
                                          input logic [2:0] e);
        logic [40:0] r;
        for (int i = 0; i < 32; i++) begin
            logic home;
            home = (i < 14) ? x0[i] : x1[i-14];
            r[i] = s[i] ? x2[i] : home;
        end
        r[37:32] = x1[23:18];
        r[38] = e[0] & |(x0 & s[13:0]);
        r[39] = e[1] & |(x1[17:0] & s[31:14]);
        r[40] = e[2] & |(x2 & ~s);
        return r;
    endfunction

    // Compare one vector; mismatches are reported per requirement group.
    task automatic compare(input logic [40:0] exp, input logic [31:0] s, input logic [2:0] e,
                           input string note);
        bit bad = 0;
        n_chk++;
        for (int i = 0; i < 32; i++) begin
            if (line[i] !== exp[i]) begin
                bad = 1;
                $display("FAIL %s line %0d (%s) got %b exp %b", s[i] ? "R3" : "R2", i, note, line[i], exp[i]);
            end
        end
        if (line[37:32] !== exp[37:32]) begin
            bad = 1;
            $display("FAIL R4 (%s) got %h exp %h", note, line[37:32], exp[37:32]);
        end
        if (line[38] !== exp[38]) begin
            bad = 1;
            $display("FAIL %s line 38 (%s) got %b exp %b", e[0] ? "R5" : "R8", note, line[38], exp[38]);
        end
        if (line[39] !== exp[39]) begin
            bad = 1;
            $display("FAIL %s line 39 (%s) got %b exp %b", e[1] ? "R6" : "R8", note, line[39], exp[39]);
        end
        if (line[40] !== exp[40]) begin
            bad = 1;
            $display("FAIL %s line 40 (%s) got %b exp %b", e[2] ? "R7" : "R8", note, line[40], exp[40]);
        end
        if (bad) n_bad++;
    endtask

    task automatic apply(input logic [13:0] x0, input logic [23:0] x1, input logic [31:0] x2,
                         input string note);
        @(negedge clk);
        b0 = x0; b1 = x1; b2 = x2;
        @(negedge clk);
        compare(model(b0, b1, b2, m_sel, m_en), m_sel, m_en, note);
    endtask

    // Write, then confirm the old mapping is still visible one edge later (R10).
    task automatic cfg_write(input logic a, input logic [31:0] d);
        logic [31:0] old_s;
        logic [2:0]  old_e;
        old_s = m_sel; old_e = m_en;
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
        if (a) m_en = d[2:0];
        else   m_sel = d;
        compare(model(b0, b1, b2, old_s, old_e), old_s, old_e, "R10 old mapping after write edge");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        b0 = '1; b1 = '1; b2 = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: after reset, select and enables zero: bank 2 absent, OR lines quiet
        n_chk++;
        if (line !== {3'b000, 6'h3F, 32'hFFFF_FFFF}) begin
            n_bad++;
            $display("FAIL R1 reset state got %h exp %h", line, {3'b000, 6'h3F, 32'hFFFF_FFFF});
        end
        // R1: select zero after reset, bank 2 alone must not reach lines 0..31
        apply('0, '0, 32'hFFFF_FFFF, "R1 bank2 hidden at reset select");
        // R8: enables off, all sources high
        apply('1, '1, '1, "R8 all high, enables off");
        // R9: upper data bits ignored on enable write
        cfg_write(1'b1, 32'hFFFF_FFF8);
        apply('1, '1, '1, "R9 upper enable bits ignored");
        cfg_write(1'b1, 32'h0000_0007);
        // R7: default select, single bank2 bit lands on line 40
        apply('0, '0, 32'h0001_0000, "R7 bank2 folded");
        // R3/R5: every line stolen, bank 0 folds into line 38
        cfg_write(1'b0, 32'hFFFF_FFFF);
        apply('1, '0, '0, "R5 bank0 folded under full select");
        apply('0, '0, 32'hA5A5_5A5A, "R3 bank2 direct");
        // R6: only bank-1 upper bits high, line 39 must stay low
        apply('0, 24'hFC_0000, '0, "R6 upper bank1 never folds");
        apply('0, 24'h02_0000, '0, "R6 bank1 bit17 folds");
        // R2/R4: mixed select
        cfg_write(1'b0, 32'h0000_4001);
        apply(14'h0001, 24'h00_0001, 32'h0000_4001, "R2 mixed select");
        // random mix
        for (int n = 0; n < 300; n++) begin
            if ((n % 25) == 0) begin
                cfg_write(1'b0, $urandom);
                cfg_write(1'b1, $urandom);
            end
            apply(14'($urandom), 24'($urandom), $urandom, "random");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule